// File: doc/BRIEF.md
# Echo-Clocked Dual-Channel Sample Deserializer

This block receives serial conversion results from a two-channel precision SAR converter running with its clock looped back. The host produces the serial clock and the chip select elsewhere. The converter sends that clock back on its busy/clock-out pin, and this block latches the data lanes on the returned edge. The local clock is never used for capture. While the transfer runs, the serial controller still drives the interface but ignores the incoming data, so this block is the only one that captures it.

A frame holds one sample from each of the two channels. The lane arrangement is a parameter with four options: one lane carrying both channels one after the other, or one, two or four lanes for each channel. The data rate is also a parameter: single rate captures on rising edges only, and double rate captures on both edges. When a frame is complete, the pair of words crosses into the system clock domain through a small gray-coded asynchronous FIFO. The pair then leaves as a valid/ready stream of single words, channel 0 first, toward a DMA. The sample width is 24 or 16 bits.

Top module: `echo_lane_capture`

## Requirements
- R1: Lane data is captured only on edges of `echo_clk_i`. With `DDR_EN`=0 capture happens on every rising edge.
- R2: With `LANES`=1, lane 0 carries the channel 0 word MSB first, then the channel 1 word MSB first, so a frame is 2·`SAMPLE_W` beats long.
- R3: With `LANES`=2, 4 or 8, let P = `LANES`/2. Channel c uses lanes c·P to c·P+P−1. Bit k of the word, counted from the MSB (k=0), is on lane c·P + (k mod P) at beat k/P.
- R4: With `DDR_EN`=1, beats are taken on alternate edges. Beat 0 is on a rising edge, beat 1 on the next falling edge, and so on, so a frame needs half as many clock periods.
- R5: While `cs_ni` is high the beat counter is held at zero. A frame cut short by `cs_ni` going high produces no output and does not shift the alignment of the next frame.
- R6: Exactly one sample pair is released per frame, and only after the full beat count (2·`SAMPLE_W`/`LANES`) has been received.
- R7: Each pair leaves as two stream words. The channel 0 word comes first with `m_chan_o`=0, then the channel 1 word with `m_chan_o`=1.
- R8: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o`, `m_data_o` and `m_chan_o` stay unchanged.
- R9: At most `FIFO_DEPTH`+1 pairs are buffered, counting the pair in the output register. A complete frame that arrives when the FIFO is full is discarded whole.
- R10: While `rst_ni` is low, and afterwards until a frame completes, `m_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the output stream |
| rst_ni | input | 1 | Active-low asynchronous reset |
| echo_clk_i | input | 1 | Serial clock returned by the converter |
| cs_ni | input | 1 | Active-low frame select; high clears the beat counter |
| lanes_i | input | LANES | Serial data lanes |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | SAMPLE_W | Sample word |
| m_chan_o | output | 1 | Channel of the current word |

## Verification
The bench checks three configurations: one interleaved lane at single rate, four lanes at double rate, and eight lanes with 16-bit samples. If the lane mapping or the bit order were wrong, every word would scramble. If the rising and falling beats were swapped in double-rate mode, the bits within each pair would be exchanged. The bench sends frames that are cut short at an even beat count. A counter that was not cleared by chip select would make the next full frame come out misaligned, or produce an extra word. It also holds the output ready low while six frames arrive. A FIFO with a wrong full flag would either lose one of the first five pairs or let the sixth one through, and the bench would see a mismatch or an unexpected word.

// File: rtl/echo_cap_pkg.sv
package echo_cap_pkg;

  // lane carrying bit k (0 = MSB) of channel c
  function automatic int lane_of(int c, int k, int lanes);
    if (lanes == 1) return 0;
    return c * (lanes / 2) + k % (lanes / 2);
  endfunction

  // beat (0 = first in frame) carrying bit k of channel c
  function automatic int beat_of(int c, int k, int lanes, int w);
    if (lanes == 1) return c * w + k;
    return k / (lanes / 2);
  endfunction

endpackage

// File: rtl/echo_deser.sv
module echo_deser
  import echo_cap_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int LANES    = 2,
  parameter bit DDR_EN   = 1'b0
) (
  input  logic                  echo_clk_i,
  input  logic                  cap_clk_i,
  input  logic                  frame_rst_i,
  input  logic [LANES-1:0]      lanes_i,
  output logic                  push_o,
  output logic [2*SAMPLE_W-1:0] pair_o
);
  localparam int BEATS  = 2 * SAMPLE_W / LANES;
  localparam int EVENTS = DDR_EN ? BEATS / 2 : BEATS;
  localparam int CW     = $clog2(EVENTS) + 1;

  logic [EVENTS-1:0] main_sr  [LANES];
  logic [EVENTS-1:0] main_nxt [LANES];
  logic [BEATS-1:0]  seq      [LANES];
  logic [CW-1:0]     cnt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign main_nxt[l] = {main_sr[l][EVENTS-2:0], lanes_i[l]};

    always_ff @(posedge cap_clk_i or posedge frame_rst_i) begin
      if (frame_rst_i) main_sr[l] <= '0;
      else             main_sr[l] <= main_nxt[l];
    end

    if (DDR_EN) begin : g_ddr
      logic [EVENTS-1:0] rise_sr;
      always_ff @(posedge echo_clk_i or posedge frame_rst_i) begin
        if (frame_rst_i) rise_sr <= '0;
        else             rise_sr <= {rise_sr[EVENTS-2:0], lanes_i[l]};
      end
      // even beats on rising edges, odd beats on falling edges
      always_comb begin
        for (int b = 0; b < BEATS; b++)
          seq[l][b] = (b % 2 == 0) ? rise_sr[EVENTS-1-b/2] : main_nxt[l][EVENTS-1-b/2];
      end
    end else begin : g_sdr
      always_comb begin
        for (int b = 0; b < BEATS; b++)
          seq[l][b] = main_nxt[l][EVENTS-1-b];
      end
    end
  end

  always_comb begin
    pair_o = '0;
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < SAMPLE_W; k++)
        pair_o[c*SAMPLE_W + SAMPLE_W-1-k] =
          seq[lane_of(c, k, LANES)][beat_of(c, k, LANES, SAMPLE_W)];
  end

  always_ff @(posedge cap_clk_i or posedge frame_rst_i) begin
    if (frame_rst_i)                  cnt <= '0;
    else if (cnt == CW'(EVENTS - 1)) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  assign push_o = (cnt == CW'(EVENTS - 1));

  assert_cnt_bound_R6: assert property (@(posedge cap_clk_i) disable iff (frame_rst_i)
    cnt < CW'(EVENTS));
  assert_wrap_after_push_R6: assert property (@(posedge cap_clk_i) disable iff (frame_rst_i)
    push_o |=> (cnt == '0));

endmodule

// File: rtl/echo_pair_fifo.sv
module echo_pair_fifo #(
  parameter int DW    = 48,
  parameter int DEPTH = 4
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  function automatic logic [AW:0] g2b(logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rg_s1, rg_s2, rbin_s;
  logic [AW:0] rbin, rgray, wg_s1, wg_s2;
  logic full, wr_en;

  // write side (echo domain)
  assign rbin_s = g2b(rg_s2);
  assign full   = ((wbin - rbin_s) == (AW+1)'(DEPTH));
  assign wr_en  = push_i && !full;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_en) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk_i) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wdata_i;
  end

  // read side (system domain)
  assign empty_o = (rgray == wg_s2);
  assign rdata_o = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (pop_i) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end
  end

  assert_fill_bound_R9: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wbin - rbin_s) <= (AW+1)'(DEPTH));
  assert_no_pop_empty_R9: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/echo_stream_out.sv
module echo_stream_out #(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  empty_i,
  input  logic [2*SAMPLE_W-1:0] pair_i,
  output logic                  pop_o,
  output logic                  m_valid_o,
  input  logic                  m_ready_i,
  output logic [SAMPLE_W-1:0]   m_data_o,
  output logic                  m_chan_o
);
  logic [2*SAMPLE_W-1:0] hold_q;
  logic valid_q, chan_q, fire;

  assign fire  = valid_q && m_ready_i;
  assign pop_o = !empty_i && (!valid_q || (fire && chan_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0; valid_q <= 1'b0; chan_q <= 1'b0;
    end else if (pop_o) begin
      hold_q <= pair_i; valid_q <= 1'b1; chan_q <= 1'b0;
    end else if (fire) begin
      if (!chan_q) chan_q  <= 1'b1;
      else         valid_q <= 1'b0;
    end
  end

  assign m_valid_o = valid_q;
  assign m_chan_o  = chan_q;
  assign m_data_o  = chan_q ? hold_q[2*SAMPLE_W-1:SAMPLE_W] : hold_q[SAMPLE_W-1:0];

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_chan_o)));
  assert_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i && !m_chan_o) |=> (m_valid_o && m_chan_o));

endmodule

// File: rtl/echo_lane_capture.sv
module echo_lane_capture #(
  parameter int SAMPLE_W   = 24,
  parameter int LANES      = 2,
  parameter bit DDR_EN     = 1'b0,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                echo_clk_i,
  input  logic                cs_ni,
  input  logic [LANES-1:0]    lanes_i,
  output logic                m_valid_o,
  input  logic                m_ready_i,
  output logic [SAMPLE_W-1:0] m_data_o,
  output logic                m_chan_o
);
  localparam int PW = 2 * SAMPLE_W;

  logic cap_clk, frame_rst, push, pop, empty;
  logic [PW-1:0] pair, fifo_rdata;

  // DDR: frame completes on a falling edge, so the write side runs inverted
  assign cap_clk   = DDR_EN ? ~echo_clk_i : echo_clk_i;
  assign frame_rst = cs_ni | ~rst_ni;

  echo_deser #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .DDR_EN(DDR_EN)) u_deser (
    .echo_clk_i (echo_clk_i),
    .cap_clk_i  (cap_clk),
    .frame_rst_i(frame_rst),
    .lanes_i    (lanes_i),
    .push_o     (push),
    .pair_o     (pair)
  );

  echo_pair_fifo #(.DW(PW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wr_clk_i(cap_clk),
    .rd_clk_i(clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (pair),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .empty_o (empty)
  );

  echo_stream_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .empty_i  (empty),
    .pair_i   (fifo_rdata),
    .pop_o    (pop),
    .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i),
    .m_data_o (m_data_o),
    .m_chan_o (m_chan_o)
  );

  assert_idle_in_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !m_valid_o);

endmodule

// File: tb/sim_echo_lane_capture.sv
module sim_echo_lane_capture;
  localparam int WS [3] = '{24, 24, 16};
  localparam int LS [3] = '{1, 4, 8};
  localparam bit DS [3] = '{1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] eclk = '0;
  logic [2:0] csn  = '1;
  logic [2:0] rdy  = '0;
  logic [2:0] hold = '0;
  logic [7:0] lanes_v [3];

  logic v0, v1, v2, c0, c1, c2;
  logic [23:0] d0, d1;
  logic [15:0] d2;

  int checks = 0;
  int fails  = 0;
  int q [3][$];

  echo_lane_capture #(.SAMPLE_W(24), .LANES(1), .DDR_EN(1'b0), .FIFO_DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .echo_clk_i(eclk[0]), .cs_ni(csn[0]),
    .lanes_i(lanes_v[0][0:0]), .m_valid_o(v0), .m_ready_i(rdy[0]),
    .m_data_o(d0), .m_chan_o(c0));

  echo_lane_capture #(.SAMPLE_W(24), .LANES(4), .DDR_EN(1'b1), .FIFO_DEPTH(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .echo_clk_i(eclk[1]), .cs_ni(csn[1]),
    .lanes_i(lanes_v[1][3:0]), .m_valid_o(v1), .m_ready_i(rdy[1]),
    .m_data_o(d1), .m_chan_o(c1));

  echo_lane_capture #(.SAMPLE_W(16), .LANES(8), .DDR_EN(1'b0), .FIFO_DEPTH(4)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .echo_clk_i(eclk[2]), .cs_ni(csn[2]),
    .lanes_i(lanes_v[2][7:0]), .m_valid_o(v2), .m_ready_i(rdy[2]),
    .m_data_o(d2), .m_chan_o(c2));

  function automatic logic get_v(int i);
    case (i) 0: return v0; 1: return v1; default: return v2; endcase
  endfunction
  function automatic logic get_c(int i);
    case (i) 0: return c0; 1: return c1; default: return c2; endcase
  endfunction
  function automatic logic [23:0] get_d(int i);
    case (i) 0: return d0; 1: return d1; default: return {8'h0, d2}; endcase
  endfunction
  function automatic string tags(int i);
    case (i) 0: return "R1,R2,R7"; 1: return "R3,R4,R7"; default: return "R3,R6,R7"; endcase
  endfunction

  // lane values for one beat, derived beat-first from the lane rules
  function automatic logic [7:0] beat_val(int w, int l, logic [23:0] a, logic [23:0] b, int bt);
    logic [7:0] r = '0;
    for (int ln = 0; ln < l; ln++) begin
      int c, k;
      if (l == 1) begin c = bt / w; k = bt % w; end
      else begin c = ln / (l / 2); k = bt * (l / 2) + ln % (l / 2); end
      r[ln] = (c == 0) ? a[w-1-k] : b[w-1-k];
    end
    return r;
  endfunction

  task automatic send(int i, logic [23:0] a_in, logic [23:0] b_in, int nb, bit exp);
    logic [23:0] msk, a, b;
    msk = (WS[i] == 24) ? 24'hFFFFFF : 24'h00FFFF;
    a = a_in & msk; b = b_in & msk;
    csn[i] = 1'b0;
    #5;
    for (int bt = 0; bt < nb; bt++) begin
      lanes_v[i] = beat_val(WS[i], LS[i], a, b, bt);
      #4;
      if (DS[i]) eclk[i] = ~eclk[i];
      else eclk[i] = 1'b1;
      #4;
      if (!DS[i]) eclk[i] = 1'b0;
    end
    #5;
    if (exp) begin
      q[i].push_back({8'h0, a});
      q[i].push_back(32'h0100_0000 | {8'h0, b});
    end
    csn[i] = 1'b1;
    #10;
  endtask

  // reference comparison every system clock
  logic [2:0] pv = '0, pr = '0, pc = '0;
  logic [23:0] pd [3];
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        // R8: held word must not move while stalled
        if (pv[i] && !pr[i]) begin
          checks++;
          if (!get_v(i) || get_d(i) != pd[i] || get_c(i) != pc[i]) begin
            fails++;
            $display("FAIL R8 u%0d: v=%0b d=%h c=%0b expected v=1 d=%h c=%0b",
                     i, get_v(i), get_d(i), get_c(i), pd[i], pc[i]);
          end
        end
        rdy[i] = hold[i] ? 1'b0 : ($urandom % 4 != 0);
        if (get_v(i) && rdy[i]) begin
          checks++;
          if (q[i].size() == 0) begin
            fails++;
            $display("FAIL R5,R6,R9 u%0d: unexpected word d=%h c=%0b expected none",
                     i, get_d(i), get_c(i));
          end else begin
            int e;
            e = q[i].pop_front();
            if (get_d(i) != e[23:0] || get_c(i) != e[24]) begin
              fails++;
              $display("FAIL %s u%0d: d=%h c=%0b expected d=%h c=%0b",
                       tags(i), i, get_d(i), get_c(i), e[23:0], e[24]);
            end
          end
        end
        pv[i] = get_v(i); pr[i] = rdy[i]; pc[i] = get_c(i); pd[i] = get_d(i);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) lanes_v[i] = '0;
    repeat (4) @(negedge clk);
    // R10: idle during reset
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (get_v(i)) begin
        fails++;
        $display("FAIL R10 u%0d: valid=1 expected 0 in reset", i);
      end
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (get_v(i)) begin
        fails++;
        $display("FAIL R10 u%0d: valid=1 expected 0 after reset", i);
      end
    end

    // R1 R2 R3 R4 R6: fixed and random patterns on each arrangement
    for (int i = 0; i < 3; i++) begin
      int nb;
      nb = 2 * WS[i] / LS[i];
      send(i, 24'hFFFFFF, 24'h000000, nb, 1'b1);
      send(i, 24'h800001, 24'hA5A5A5, nb, 1'b1);
      send(i, 24'h123456, 24'hFEDCBA, nb, 1'b1);
      for (int n = 0; n < 5; n++) send(i, $urandom, $urandom, nb, 1'b1);
      // R5: aborted frame, then a clean one must stay aligned
      send(i, 24'h5A5A5A, 24'h3C3C3C, (nb / 2) & ~1, 1'b0);
      send(i, 24'hC0FFEE, 24'h0BADF0, nb, 1'b1);
    end
    repeat (100) @(negedge clk);

    // R9: six frames with ready held low, only five retained
    hold[0] = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 6; n++)
      send(0, 24'h100000 + n, 24'h200000 + n, 48, n < 5);
    repeat (20) @(negedge clk);
    hold[0] = 1'b0;

    repeat (300) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (q[i].size() != 0) begin
        fails++;
        $display("FAIL R6,R9 u%0d: %0d words missing, expected 0", i, q[i].size());
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule